// File: doc/BRIEF.md
# External Request DMA Channel Sequencer

This block is the pin-facing sequencer of one DMA channel. It watches an asynchronous transfer-request input and, once a request is accepted, runs a programmed number of transfer units on a simple bus-access port. It also drives the active-low acknowledge, end-of-process and fly-by I/O strobe pins that external devices expect.

The request input can work in two ways. In edge mode a transfer starts on a clean edge of the selected polarity. In demand mode the request is a level, and transfers proceed only while that level is high.

The bus port uses valid/ready. An access is offered by raising `bus_valid` with `bus_write` and `bus_addr`. The access completes on the first rising clock edge where `bus_ready` is also high. While `bus_valid` is high and `bus_ready` is low, the sequencer holds every access output steady. There is no timeout, so back-pressure can last any number of cycles. `bus_addr` is the index of the transfer unit, counted from zero for each transfer.

Top module: `dma_xreq_seq`

## Requirements
- R1: In edge mode (`cfg_demand`=0), a transfer starts only after a qualified edge of `req_in`. `cfg_edge_fall`=0 selects rising edges and `cfg_edge_fall`=1 selects falling edges. An edge of the other polarity starts nothing.
- R2: `req_in` passes a two-stage synchronizer. An edge qualifies only if the new level then stays stable for 3 consecutive synchronized clock cycles. A pulse that holds for 2 cycles is discarded, and one that holds for 3 cycles is accepted.
- R3: Edges that qualify while the channel is busy (`busy`=1) are ignored and are not remembered. Once `busy` has returned to 0, a new qualified edge starts a new transfer.
- R4: `ack_n` is 0 in exactly the cycles where `bus_valid` is 1.
- R5: `eop_n` is 0 only while the final access of a transfer is being offered. It stays 0 until that access completes, so each transfer produces exactly one completed access with `eop_n`=0. `busy` drops on the clock edge that completes it.
- R6: In two-cycle mode (`cfg_flyby`=0), each unit is one read access (`bus_write`=0) followed by one write access (`bus_write`=1) at the same `bus_addr`. `bus_addr` takes the values 0, 1, 2, … in turn, giving 2×count accesses per transfer. Both I/O strobes stay high.
- R7: In fly-by mode (`cfg_flyby`=1), each unit is one access, giving count accesses per transfer. With `cfg_io2mem`=1 the access is a memory write (`bus_write`=1) and `iord_n`=0 during it. With `cfg_io2mem`=0 the access is a memory read (`bus_write`=0) and `iowr_n`=0 during it. The two strobes are never low together.
- R8: In demand mode (`cfg_demand`=1), a high synchronized request starts a transfer. If the request is low when a unit ends, the channel pauses: `busy` stays 1 and no access is offered. It resumes when the request is high again, keeping its remaining count and address.
- R9: While `bus_valid`=1 and `bus_ready`=0, `bus_valid`, `bus_write` and `bus_addr` hold their values on the next cycle.
- R10: With `cfg_count`=0, no request of either kind starts a transfer, and `busy` stays 0.
- R11: Count and mode are captured when a transfer starts. Changing `cfg_count` during a transfer does not alter its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 1 | Asynchronous transfer request |
| cfg_count | input | CNT_W | Units per transfer; 0 disables the channel |
| cfg_demand | input | 1 | 1 = level (demand) mode, 0 = edge mode |
| cfg_edge_fall | input | 1 | Edge mode trigger: 0 rising, 1 falling |
| cfg_flyby | input | 1 | 1 = fly-by, 0 = two-cycle |
| cfg_io2mem | input | 1 | Fly-by direction: 1 I/O to memory, 0 memory to I/O |
| bus_valid | output | 1 | Access offered |
| bus_ready | input | 1 | Access accepted this cycle |
| bus_write | output | 1 | Access is a memory write |
| bus_addr | output | ADDR_W | Unit index within the transfer |
| busy | output | 1 | Transfer in progress (including demand pause) |
| ack_n | output | 1 | Active-low acknowledge |
| eop_n | output | 1 | Active-low end-of-process |
| iord_n | output | 1 | Active-low I/O read strobe (fly-by) |
| iowr_n | output | 1 | Active-low I/O write strobe (fly-by) |

## Verification
The bench sweeps transfer counts 1 to 4 across two-cycle mode, both fly-by directions, both trigger polarities, and free-flowing or randomly stalled ready. Each run counts accesses, writes, strobes and the end-of-process handshake against arithmetic expectations. A design that lengthened or shortened transfers, swapped the strobes, or moved end-of-process off the final access would miss these counts. A two-cycle request pulse must start nothing, while a three-cycle pulse must start a transfer; an off-by-one hold counter fails one side of that pair. A pulse during a long stalled transfer must not add a second transfer, and a pulse just after it ends must start one, which catches designs that latch stale edges or lock out too long. The demand test drops the request mid-transfer and expects a frozen access count with `busy` still high. It then clears `cfg_count` and expects the full original length once the request returns, exposing designs that abort or re-read the count.

// File: rtl/dma_xreq_pkg.sv
package dma_xreq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_FLY,
    ST_PAUSE
  } seq_state_e;

  typedef struct packed {
    logic demand;
    logic flyby;
    logic io2mem;
  } xfer_mode_s;

endpackage

// File: rtl/xreq_sync.sv
module xreq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/xreq_qual.sv
module xreq_qual #(
  parameter int HOLD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int HC_W = $clog2(HOLD_CYC + 1);

  logic            qlvl;
  logic [HC_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qlvl     <= 1'b0;
      run_cnt  <= '0;
      rise_evt <= 1'b0;
      fall_evt <= 1'b0;
    end else begin
      rise_evt <= 1'b0;
      fall_evt <= 1'b0;
      if (lvl == qlvl) begin
        run_cnt <= '0;
      end else if (run_cnt == HC_W'(HOLD_CYC - 1)) begin
        qlvl     <= lvl;
        run_cnt  <= '0;
        rise_evt <= lvl;
        fall_evt <= !lvl;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  // R2: an event is only issued after the new level was seen on the last three edges
  a_r2_hold_met: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_evt || fall_evt) |-> ($past(lvl, 1) == qlvl && $past(lvl, 2) == qlvl && $past(lvl, 3) == qlvl));

  a_r1_one_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_evt && fall_evt));
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import dma_xreq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_edge,
  input  logic              dem_lvl,
  input  logic [CNT_W-1:0]  cfg_count,
  input  xfer_mode_s        cfg_mode,
  input  logic              bus_ready,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              last_acc,
  output logic              busy,
  output xfer_mode_s        mode_q
);
  seq_state_e       state;
  logic [CNT_W-1:0] remain;
  logic             launch;
  logic             unit_end;
  seq_state_e       first_st;

  assign launch   = (cfg_count != '0) &&
                    (cfg_mode.demand ? dem_lvl : start_edge);
  assign first_st = mode_q.flyby ? ST_FLY : ST_RD;
  assign unit_end = bus_ready && (state == ST_WR || state == ST_FLY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      remain   <= '0;
      bus_addr <= '0;
      mode_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (launch) begin
            mode_q   <= cfg_mode;
            remain   <= cfg_count;
            bus_addr <= '0;
            state    <= cfg_mode.flyby ? ST_FLY : ST_RD;
          end
        end
        ST_RD: begin
          if (bus_ready) state <= ST_WR;
        end
        ST_WR, ST_FLY: begin
          if (bus_ready) begin
            if (remain == CNT_W'(1)) begin
              state <= ST_IDLE;
            end else begin
              remain   <= remain - 1'b1;
              bus_addr <= bus_addr + 1'b1;
              state    <= (mode_q.demand && !dem_lvl) ? ST_PAUSE : first_st;
            end
          end
        end
        ST_PAUSE: begin
          if (dem_lvl) state <= first_st;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_valid = (state == ST_RD) || (state == ST_WR) || (state == ST_FLY);
    unique case (state)
      ST_WR:   bus_write = 1'b1;
      ST_FLY:  bus_write = mode_q.io2mem;
      default: bus_write = 1'b0;
    endcase
    last_acc = (remain == CNT_W'(1)) && (state == ST_WR || state == ST_FLY);
    busy     = (state != ST_IDLE);
  end

  a_r9_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write)));

  a_r10_zero_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && cfg_count == '0) |=> (state == ST_IDLE));

  a_r6_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD && bus_ready) |=> (state == ST_WR && $stable(bus_addr)));

  a_r8_pause_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PAUSE && !dem_lvl) |=> (state == ST_PAUSE && !bus_valid));

  a_r3_no_restart_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !unit_end) |=> busy);
endmodule

// File: rtl/dma_xreq_seq.sv
module dma_xreq_seq
  import dma_xreq_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_in,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              cfg_demand,
  input  logic              cfg_edge_fall,
  input  logic              cfg_flyby,
  input  logic              cfg_io2mem,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              busy,
  output logic              ack_n,
  output logic              eop_n,
  output logic              iord_n,
  output logic              iowr_n
);
  logic       req_s;
  logic       rise_evt;
  logic       fall_evt;
  logic       start_edge;
  logic       last_acc;
  xfer_mode_s cfg_mode;
  xfer_mode_s mode_q;

  xreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(req_in), .q(req_s)
  );

  xreq_qual #(.HOLD_CYC(HOLD_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .lvl(req_s),
    .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  assign start_edge = cfg_edge_fall ? fall_evt : rise_evt;
  assign cfg_mode   = '{demand: cfg_demand, flyby: cfg_flyby, io2mem: cfg_io2mem};

  xfer_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_edge(start_edge), .dem_lvl(req_s),
    .cfg_count(cfg_count), .cfg_mode(cfg_mode),
    .bus_ready(bus_ready),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .last_acc(last_acc), .busy(busy), .mode_q(mode_q)
  );

  assign ack_n  = !bus_valid;
  assign eop_n  = !(bus_valid && last_acc);
  assign iord_n = !(bus_valid && mode_q.flyby && mode_q.io2mem);
  assign iowr_n = !(bus_valid && mode_q.flyby && !mode_q.io2mem);

  a_r5_eop_ends_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (!eop_n && bus_ready) |=> !busy);

  a_r7_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!iord_n, !iowr_n}));

  a_r7_iord_writes_mem: assert property (@(posedge clk) disable iff (!rst_n)
    !iord_n |-> bus_write);

  a_r4_ack_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> busy);
endmodule

// File: tb/sim_dma_xreq_seq.sv
module sim_dma_xreq_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_in = 1'b0;
  logic [CNT_W-1:0]  cfg_count = '0;
  logic              cfg_demand = 1'b0;
  logic              cfg_edge_fall = 1'b0;
  logic              cfg_flyby = 1'b0;
  logic              cfg_io2mem = 1'b0;
  logic              bus_valid;
  logic              bus_ready = 1'b1;
  logic              bus_write;
  logic [ADDR_W-1:0] bus_addr;
  logic              busy, ack_n, eop_n, iord_n, iowr_n;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  int hs, wr_hs, eop_hs, iord_hs, iowr_hs, mon_err;
  int cur_total;
  bit cur_fly, cur_io2m, stall_en;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_xreq_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .cfg_count(cfg_count),
    .cfg_demand(cfg_demand), .cfg_edge_fall(cfg_edge_fall),
    .cfg_flyby(cfg_flyby), .cfg_io2mem(cfg_io2mem),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .busy(busy), .ack_n(ack_n), .eop_n(eop_n),
    .iord_n(iord_n), .iowr_n(iowr_n)
  );

  // Ready generation and access monitor in one process at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      bus_ready = stall_en ? (lfsr[1] | lfsr[0]) : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (ack_n !== !bus_valid) mon_err++;                    // R4
      if (!eop_n && !bus_valid) mon_err++;                    // R5
      if (!cur_fly && (!iord_n || !iowr_n)) mon_err++;        // R6
      if (cur_fly && bus_valid && (iord_n != !cur_io2m || iowr_n != cur_io2m)) mon_err++; // R7
      if (bus_valid && bus_ready) begin
        if (int'(bus_addr) != (cur_fly ? hs : hs / 2)) mon_err++;
        if (bus_write != (cur_fly ? cur_io2m : (hs % 2 == 1))) mon_err++;
        if (bus_write) wr_hs++;
        if (!iord_n) iord_hs++;
        if (!iowr_n) iowr_hs++;
        if (!eop_n) begin
          eop_hs++;
          if (hs != cur_total - 1) mon_err++;
        end
        hs++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_counts(input int total, input bit fly, input bit io2m);
    hs = 0; wr_hs = 0; eop_hs = 0; iord_hs = 0; iowr_hs = 0; mon_err = 0;
    cur_total = total; cur_fly = fly; cur_io2m = io2m;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle(input string tag);
    int k;
    k = 0;
    while (busy && k < 5000) begin
      @(negedge clk);
      k++;
    end
    chk(k < 5000, {tag, " wait for idle"}, k, 5000);
  endtask

  task automatic pulse(input bit lvl, input int width);
    req_in = lvl;
    cycles(width);
    req_in = !lvl;
  endtask

  task automatic run_edge(input int cnt, input bit fly, input bit io2m,
                          input bit fall, input bit stall);
    int exp_acc;
    exp_acc = fly ? cnt : 2 * cnt;
    cfg_demand = 0; cfg_edge_fall = fall; cfg_flyby = fly; cfg_io2mem = io2m;
    cfg_count = CNT_W'(cnt); stall_en = stall;
    clr_counts(exp_acc, fly, io2m);
    if (fall) begin
      req_in = 1'b1;        // rising edge first: wrong polarity, must start nothing (R1)
      cycles(10);
      chk(hs == 0 && !busy, "R1 opposite edge ignored", hs, 0);
      req_in = 1'b0;
      cycles(12);
    end else begin
      pulse(1'b1, 5);
      cycles(12);
    end
    wait_idle("R1");
    chk(hs == exp_acc, "R6/R7 access count", hs, exp_acc);
    chk(eop_hs == 1, "R5 eop handshakes", eop_hs, 1);
    chk(mon_err == 0, "R4/R5/R6/R7 monitor", mon_err, 0);
    if (fly) begin
      chk(wr_hs == (io2m ? cnt : 0), "R7 write count", wr_hs, io2m ? cnt : 0);
      chk(iord_hs == (io2m ? cnt : 0) && iowr_hs == (io2m ? 0 : cnt),
          "R7 strobe count", iord_hs, io2m ? cnt : 0);
    end else begin
      chk(wr_hs == cnt, "R6 write count", wr_hs, cnt);
    end
    cycles(3);
  endtask

  initial begin
    clr_counts(0, 0, 0);
    stall_en = 0;
    cycles(3);
    chk(ack_n && eop_n && iord_n && iowr_n && !bus_valid && !busy,
        "R4 reset state", {ack_n, eop_n, iord_n, iowr_n, bus_valid, busy}, 6'b111100);
    rst_n = 1'b1;
    cycles(3);

    // Sweep of counts, modes, trigger polarity and back-pressure
    for (int c = 1; c <= 4; c++)
      for (int m = 0; m < 3; m++)
        for (int f = 0; f < 2; f++)
          for (int s = 0; s < 2; s++)
            run_edge(c, m != 0, m == 2, f[0], s[0]);

    // R2: two-cycle pulse discarded, three-cycle pulse accepted
    cfg_demand = 0; cfg_edge_fall = 0; cfg_flyby = 0; cfg_count = 8'd2; stall_en = 0;
    clr_counts(4, 0, 0);
    pulse(1'b1, 2);
    cycles(20);
    chk(hs == 0 && !busy, "R2 short pulse ignored", hs, 0);
    pulse(1'b1, 3);
    cycles(15);
    wait_idle("R2");
    chk(hs == 4, "R2 three-cycle pulse accepted", hs, 4);
    cycles(10);

    // R3: pulse during a long stalled transfer ignored; pulse right after accepted
    cfg_count = 8'd10; stall_en = 1;
    clr_counts(20, 0, 0);
    pulse(1'b1, 5);
    while (!busy) @(negedge clk);
    pulse(1'b1, 5);
    cycles(6);
    chk(busy == 1, "R3 still busy during second pulse", busy, 1);
    wait_idle("R3");
    cycles(20);
    chk(hs == 20 && !busy, "R3 busy-time request ignored", hs, 20);
    chk(mon_err == 0, "R3 monitor", mon_err, 0);
    cfg_count = 8'd1; stall_en = 0;
    clr_counts(2, 0, 0);
    pulse(1'b1, 3);
    cycles(12);
    wait_idle("R3");
    chk(hs == 2, "R3 new request accepted after idle", hs, 2);
    cycles(10);

    // R10: zero count, edge and demand
    cfg_count = 8'd0;
    clr_counts(0, 0, 0);
    pulse(1'b1, 6);
    cycles(15);
    chk(hs == 0 && !busy, "R10 zero count edge", hs, 0);
    cfg_demand = 1; req_in = 1'b1;
    cycles(15);
    chk(hs == 0 && !busy, "R10 zero count demand", hs, 0);
    req_in = 1'b0;
    cycles(6);

    // R8/R11: demand with pause; count cleared after start
    cfg_demand = 1; cfg_flyby = 0; cfg_count = 8'd6; stall_en = 0;
    clr_counts(12, 0, 0);
    req_in = 1'b1;
    while (!busy) @(negedge clk);
    cfg_count = 8'd0;
    while (hs < 4) @(negedge clk);
    req_in = 1'b0;
    cycles(8);
    begin
      int frozen;
      frozen = hs;
      cycles(10);
      chk(busy == 1, "R8 paused keeps busy", busy, 1);
      chk(hs == frozen && hs < 12, "R8 no access while paused", hs, frozen);
    end
    req_in = 1'b1;
    cycles(4);
    wait_idle("R8");
    cycles(15);
    chk(hs == 12 && !busy, "R11 latched count completes", hs, 12);
    chk(eop_hs == 1 && mon_err == 0, "R8 demand eop/monitor", eop_hs, 1);
    req_in = 1'b0;
    cycles(5);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end
endmodule